// File: doc/BRIEF.md
# Static Seven-Segment LCD Drive Generator

This block drives a 3½-digit liquid-crystal display whose segments are wired one line each, without multiplexing. It generates a square-wave common plate (backplane) signal from the oscillator clock. Every segment line carries that same wave: unchanged when the segment is dark, inverted when it is lit. This keeps the average DC voltage across every segment at zero.

Three decimal digits arrive as a 12-bit BCD word. The display also takes a single "leading one" for the half digit, a sign bit for the minus bar, and a lamp-test input that lights everything. These inputs are sampled only at a backplane transition. As a result, no segment waveform ever carries a shortened half-period. Analog level shifting and output drive strength belong to the pads and are not part of this block.

Top module: `lcd_static_drv`

## Requirements
- R1: `bp_out` is a 50% duty square wave. It is low during reset and toggles every `HALF_DIV` clocks: its first toggle comes on the `HALF_DIV`-th rising edge after reset is released, and every later toggle comes `HALF_DIV` edges after the previous one. With `HALF_DIV` = 400 the backplane runs at the clock divided by 800.
- R2: Every segment output equals `bp_out` when its segment is dark and equals the inverse of `bp_out` when its segment is lit.
- R3: The digits use a standard seven-segment font. Units come from `bcd_in[3:0]`, tens from `bcd_in[7:4]` and hundreds from `bcd_in[11:8]`. In each seven-bit segment bus, bit 0 is segment a and bit 6 is segment g (order a,b,c,d,e,f,g). The lit patterns (g..a, hex) for digits 0 through 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R4: A digit whose BCD code is 10 to 15 is blank: all seven of its segments are dark.
- R5: `seg_half` is one line driving both strokes of the leading "1". It is lit exactly when the captured `lead_one` is 1.
- R6: `seg_minus` is lit exactly when the captured `neg` is 1.
- R7: While the captured `lamp_test` is 1, all 23 segment lines are lit, so the display reads -1888.
- R8: `bcd_in`, `lead_one`, `neg` and `lamp_test` are captured only on the clock edge at which `bp_out` toggles. A change between toggles has no effect on any segment output until the next toggle.
- R9: After reset, before the first toggle, the captured state is all digits blank and all flags 0. All segment outputs are therefore dark, which means 0 because `bp_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bcd_in | input | 12 | Three BCD digits: hundreds, tens, units (units in the low nibble) |
| lead_one | input | 1 | Light the half digit |
| neg | input | 1 | Light the minus sign |
| lamp_test | input | 1 | Light all segments |
| bp_out | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units digit segments a..g (bit 0 = a) |
| seg_tens | output | 7 | Tens digit segments a..g (bit 0 = a) |
| seg_hund | output | 7 | Hundreds digit segments a..g (bit 0 = a) |
| seg_half | output | 1 | Half-digit "1" (both strokes) |
| seg_minus | output | 1 | Minus sign |

## Verification
The bench builds the block with `HALF_DIV` = 5 in place of 400. With that value a backplane half-period lasts five clocks, so dozens of toggles and capture edges fit into a short run. That brings within reach:
- inputs that change mid-half-period and again right at the capture edge;
- every BCD code, including the six blank codes;
- lamp test switched on and off across several backplane phases.

A behavioural model counts clocks and keeps its own captured copy of the inputs. The whole output set is compared against it on every clock.

// File: rtl/lcd_drv_pkg.sv
// Package: shared types and constants for the static LCD drive generator.
// Assumes segment order a..g maps to bits 0..6.
package lcd_drv_pkg;
    localparam int SEGS_PER_DIGIT = 7;
    localparam int BCD_W          = 4;
    localparam int NUM_DIGITS     = 3;

    typedef logic [SEGS_PER_DIGIT-1:0] seg7_t;
    typedef logic [BCD_W-1:0]          bcd_t;

    // Code used in reset to mean "nothing shown"
    localparam bcd_t BCD_BLANK = 4'hF;
    localparam seg7_t SEG_ALL  = '1;
endpackage

// File: rtl/lcd_bp_gen.sv
// Module: lcd_bp_gen
// Produces the backplane square wave by toggling every HALF_DIV clocks.
// Emits a one-clock strobe 'edge_o' in the cycle whose rising edge toggles bp_o.
// Assumes HALF_DIV >= 2.
module lcd_bp_gen #(
    parameter int HALF_DIV = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_o,
    output logic edge_o
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign edge_o = (cnt_q == LAST);

    // Count clocks within a half-period and flip the backplane at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bp_o  <= 1'b0;
        end else if (edge_o) begin
            cnt_q <= '0;
            bp_o  <= ~bp_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: counter never leaves its range
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R1: backplane changes only after a full half-period of counting
    a_r1_bp_toggle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_o != $past(bp_o)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/lcd_digit_dec.sv
// Module: lcd_digit_dec
// Converts one BCD code into lit-segment bits a..g (bit 0 = a).
// Codes 10..15 give an all-dark digit.
module lcd_digit_dec
    import lcd_drv_pkg::*;
(
    input  bcd_t  code_i,
    output seg7_t lit_o
);
    // Font lookup for a single digit
    always_comb begin
        unique case (code_i)
            4'd0:    lit_o = 7'h3F;
            4'd1:    lit_o = 7'h06;
            4'd2:    lit_o = 7'h5B;
            4'd3:    lit_o = 7'h4F;
            4'd4:    lit_o = 7'h66;
            4'd5:    lit_o = 7'h6D;
            4'd6:    lit_o = 7'h7D;
            4'd7:    lit_o = 7'h07;
            4'd8:    lit_o = 7'h7F;
            4'd9:    lit_o = 7'h6F;
            default: lit_o = 7'h00;
        endcase
    end
endmodule

// File: rtl/lcd_seg_phase.sv
// Module: lcd_seg_phase
// Turns lit bits into AC drive: a lit line is the inverted backplane,
// a dark line follows it. Purely combinational.
module lcd_seg_phase #(
    parameter int W = 23
) (
    input  logic [W-1:0] lit_i,
    input  logic         bp_i,
    output logic [W-1:0] drv_o
);
    // Per-line phase select
    always_comb begin
        drv_o = lit_i ^ {W{bp_i}};
    end
endmodule

// File: rtl/lcd_static_drv.sv
// Module: lcd_static_drv (top)
// Static 3 1/2 digit LCD drive generator. It samples the display data on
// backplane toggles, decodes the digits, applies lamp test and phases every
// segment line against the backplane.
// Assumes the data inputs are synchronous to clk.
module lcd_static_drv
    import lcd_drv_pkg::*;
#(
    parameter int HALF_DIV = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bcd_in,
    input  logic        lead_one,
    input  logic        neg,
    input  logic        lamp_test,
    output logic        bp_out,
    output logic [6:0]  seg_units,
    output logic [6:0]  seg_tens,
    output logic [6:0]  seg_hund,
    output logic        seg_half,
    output logic        seg_minus
);
    localparam int NLINES = NUM_DIGITS * SEGS_PER_DIGIT + 2;

    logic        bp;
    logic        cap_edge;
    bcd_t        dig_q [NUM_DIGITS];
    seg7_t       dig_lit [NUM_DIGITS];
    seg7_t       dig_on [NUM_DIGITS];
    logic        lead_q;
    logic        neg_q;
    logic        lamp_q;
    logic [NLINES-1:0] lit_all;
    logic [NLINES-1:0] drv_all;

    lcd_bp_gen #(.HALF_DIV(HALF_DIV)) u_bp (
        .clk    (clk),
        .rst_n  (rst_n),
        .bp_o   (bp),
        .edge_o (cap_edge)
    );

    // Capture the flag inputs only on a backplane toggle edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= 1'b0;
            neg_q  <= 1'b0;
            lamp_q <= 1'b0;
        end else if (cap_edge) begin
            lead_q <= lead_one;
            neg_q  <= neg;
            lamp_q <= lamp_test;
        end
    end

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        // Capture this digit's BCD code on a backplane toggle edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dig_q[d] <= BCD_BLANK;
            end else if (cap_edge) begin
                dig_q[d] <= bcd_in[d*BCD_W +: BCD_W];
            end
        end

        lcd_digit_dec u_dec (
            .code_i (dig_q[d]),
            .lit_o  (dig_lit[d])
        );

        // Lamp test overrides the font
        assign dig_on[d] = lamp_q ? SEG_ALL : dig_lit[d];
    end

    assign lit_all = {neg_q | lamp_q, lead_q | lamp_q,
                      dig_on[2], dig_on[1], dig_on[0]};

    lcd_seg_phase #(.W(NLINES)) u_phase (
        .lit_i (lit_all),
        .bp_i  (bp),
        .drv_o (drv_all)
    );

    assign bp_out    = bp;
    assign seg_units = drv_all[6:0];
    assign seg_tens  = drv_all[13:7];
    assign seg_hund  = drv_all[20:14];
    assign seg_half  = drv_all[21];
    assign seg_minus = drv_all[22];

    // R8: the lit state of every line only changes across a backplane toggle
    a_r8_hold_between_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(bp_out) |-> ($stable(seg_units) && $stable(seg_tens) &&
                             $stable(seg_hund) && $stable(seg_half) &&
                             $stable(seg_minus)));

    // R7: lamp test makes every line the inverse of the backplane
    a_r7_lamp_all_lit: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_q |-> (seg_units == {7{~bp_out}} && seg_tens == {7{~bp_out}} &&
                    seg_hund == {7{~bp_out}} && seg_half == ~bp_out &&
                    seg_minus == ~bp_out));

    // R4: a captured non-decimal units code shows dark without lamp test
    a_r4_units_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_q && dig_q[0] > 4'd9) |-> (seg_units == {7{bp_out}}));

    // R6: minus line phase agrees with captured sign
    a_r6_minus_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_q) |-> ((seg_minus ^ bp_out) == neg_q));
endmodule

// File: tb/lcd_static_drv_tb.sv
module lcd_static_drv_tb;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bcd_in = '0;
    logic        lead_one = 1'b0;
    logic        neg = 1'b0;
    logic        lamp_test = 1'b0;
    logic        bp_out;
    logic [6:0]  seg_units, seg_tens, seg_hund;
    logic        seg_half, seg_minus;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    lcd_static_drv #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .lead_one(lead_one),
        .neg(neg), .lamp_test(lamp_test), .bp_out(bp_out),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
        .seg_half(seg_half), .seg_minus(seg_minus)
    );

    always #4 clk = ~clk; // 125 MHz

    // Behavioural model state
    int m_phase_cnt = 0;
    bit m_bp = 0;
    int m_dig [3] = '{15, 15, 15};
    bit m_lead = 0, m_neg = 0, m_lamp = 0;

    function automatic logic [6:0] font(int v);
        case (v)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase_cnt <= 0; m_bp <= 0;
            m_dig <= '{15, 15, 15};
            m_lead <= 0; m_neg <= 0; m_lamp <= 0;
        end else if (m_phase_cnt == HALF - 1) begin
            m_phase_cnt <= 0; m_bp <= ~m_bp;
            m_dig[0] <= int'(bcd_in[3:0]);
            m_dig[1] <= int'(bcd_in[7:4]);
            m_dig[2] <= int'(bcd_in[11:8]);
            m_lead <= lead_one; m_neg <= neg; m_lamp <= lamp_test;
        end else begin
            m_phase_cnt <= m_phase_cnt + 1;
        end
    end

    task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (sampled on the falling edge)
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            logic [6:0] inv;
            inv = {7{m_bp}};
            chk("R1 bp", {6'b0, bp_out}, {6'b0, m_bp});
            for (int d = 0; d < 3; d++) begin
                logic [6:0] lit, act;
                lit = m_lamp ? 7'h7F : font(m_dig[d]);
                act = (d == 0) ? seg_units : (d == 1) ? seg_tens : seg_hund;
                if (m_lamp)           chk("R7 digit", act, lit ^ inv);
                else if (m_dig[d] > 9) chk("R4 digit", act, lit ^ inv);
                else                   chk("R3/R2 digit", act, lit ^ inv);
            end
            chk("R5 half", {6'b0, seg_half}, {6'b0, (m_lead | m_lamp) ^ m_bp});
            chk("R6 minus", {6'b0, seg_minus}, {6'b0, (m_neg | m_lamp) ^ m_bp});
        end
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic halves(int n);
        repeat (n * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, nothing lit, backplane low
        @(negedge clk);
        chk("R9 reset units", seg_units, 7'h00);
        chk("R9 reset tens", seg_tens, 7'h00);
        chk("R9 reset hund", seg_hund, 7'h00);
        chk("R9 reset flags", {4'b0, seg_half, seg_minus, bp_out}, 7'h00);
        // R1: first toggle on HALF-th edge after release (one edge used above)
        repeat (HALF - 2) @(negedge clk);
        chk("R1 before toggle", {6'b0, bp_out}, 7'h0);
        @(negedge clk);
        chk("R1 first toggle", {6'b0, bp_out}, 7'h1);

        // Walk through all 16 codes in every position
        for (int v = 0; v < 16; v++) begin
            bcd_in = {4'(v), 4'((v + 3) % 16), 4'((v + 7) % 16)};
            lead_one = v[0]; neg = v[1];
            halves(2);
        end

        // R8: mid-half change must not reach the outputs
        bcd_in = 12'h123; lead_one = 0; neg = 0;
        halves(1);
        @(negedge clk);
        bcd_in = 12'h888; neg = 1;
        @(negedge clk);
        chk("R8 units held", seg_units ^ {7{bp_out}}, 7'h4F);
        chk("R8 minus held", {6'b0, seg_minus ^ bp_out}, 7'h0);
        halves(2);
        chk("R8 units updated", seg_units ^ {7{bp_out}}, 7'h7F);

        // R7: lamp test on and off across phases
        lamp_test = 1; bcd_in = 12'hFA0;
        halves(3);
        chk("R7 lamp tens", seg_tens ^ {7{bp_out}}, 7'h7F);
        lamp_test = 0;
        halves(3);
        chk("R4 blank hund", seg_hund ^ {7{bp_out}}, 7'h00);

        // Change inputs exactly around capture edges
        for (int k = 0; k < 20; k++) begin
            bcd_in = 12'(k * 37); lamp_test = (k % 5 == 0); neg = k[0];
            lead_one = k[1];
            repeat (k % 7 + 1) @(negedge clk);
        end
        halves(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule